// File: doc/BRIEF.md
# CCD Frame Readout Timing Generator

This block is a synchronous sequencer for a full-frame CCD whose lines are read through two serial output registers. A start request launches a frame that passes through three phases in a fixed order. First a fast clearing pass flushes every image line to the drain. Then an integration period lasts a programmable number of line times. Last comes a line-by-line readout. All outputs are logic-level phase signals for external clock drivers and for off-chip correlated double sampling.

Each line time has two parts. A horizontal blanking interval comes first. During readout it carries one image-gate shift followed by one transfer-gate pulse. During integration it carries a burst of antiblooming gate pulses. A serial period follows, of at least as many pixels as one register holds. In readout the two serial clocks run in antiphase. Each channel gets its own reset, clamp and sample strobe in every pixel. A dark-reference clamp marks the shielded columns. Composite sync and blanking frame every line. The serial count, burst length, integration length and sample delay are captured when a frame starts.

Top module: `ccd_frame_seq`

## Requirements
- R1: A start request seen while idle raises busy_o at the next clock edge and captures all run-time settings. Busy stays high for exactly LINES*CLR_CYC + (int_lines + LINES)*(HB_CYC + S*PIX_CYC) cycles, where S is the effective serial count. A start request or a change of settings while busy has no effect on that frame.
- R2: The clearing pass makes LINES image-gate pulses, each in a step of CLR_CYC cycles and high for its first CLR_CYC/2 cycles. Both reset gates are held high for the whole pass and blank is high.
- R3: Integration lasts int_lines line times with no image, transfer or serial pulses. Each of its blanking intervals carries min(ab_cnt_i, HB_CYC/2) antiblooming pulses, one cycle high and one low, starting at blanking cycle 0. A value of 0 for int_lines skips integration.
- R4: Readout lasts LINES line times. In each blanking interval the image gate is high for cycles 0..IAG_W-1 and the transfer gate is then high for the next TRG_W cycles.
- R5: The effective serial count S is max(ser_cnt_i, DATA_EL+DUMMY_EL). Each serial period holds S pixels of PIX_CYC cycles. Channel A's serial clock is high in the first PIX_CYC/2 cycles of each pixel.
- R6: During readout serial periods, channel B's serial clock is the inverse of channel A's. Both clocks are low at all other times.
- R7: Each channel's reset gate pulses for one cycle in the first cycle of its own serial clock's high half, once per pixel.
- R8: Each channel's clamp strobe is high for one cycle, right after its reset pulse and while its serial clock is still high.
- R9: Each channel's sample strobe is high sh_dly_i cycles after its serial clock falls. Channel B skips the first pixel of a line.
- R10: Both dark-reference clamps are high during pixels DUMMY_EL to DUMMY_EL+DARK_PIX-1 of every readout serial period, and low otherwise.
- R11: Composite blanking is high throughout clearing and throughout every blanking interval. It is low in serial periods and when idle.
- R12: Composite sync is high for the first SYNC_W cycles of each blanking interval. It is high for the first 2*SYNC_W cycles on the first line after clearing.
- R13: When idle, every phase and strobe output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| ser_cnt_i | input | SER_W | Serial pixels per line (raised to the minimum) |
| int_lines_i | input | INT_W | Integration length in line times |
| ab_cnt_i | input | AB_W | Antiblooming pulses per blanking interval |
| sh_dly_i | input | clog2(PIX_CYC)-1 | Sample delay after a serial clock falls |
| busy_o | output | 1 | Frame in progress |
| img_shift_o | output | 1 | Image-area line shift gate |
| ab_gate_o | output | 1 | Antiblooming gate |
| xfer_o | output | 1 | Transfer gate |
| ser_a_o | output | 1 | Serial clock, channel A |
| ser_b_o | output | 1 | Serial clock, channel B |
| rg_a_o | output | 1 | Reset gate, channel A |
| rg_b_o | output | 1 | Reset gate, channel B |
| clamp_a_o | output | 1 | Pixel clamp strobe, channel A |
| clamp_b_o | output | 1 | Pixel clamp strobe, channel B |
| samp_a_o | output | 1 | Sample strobe, channel A |
| samp_b_o | output | 1 | Sample strobe, channel B |
| dclamp_a_o | output | 1 | Dark-reference clamp, channel A |
| dclamp_b_o | output | 1 | Dark-reference clamp, channel B |
| sync_o | output | 1 | Composite sync |
| blank_o | output | 1 | Composite blanking |

## Verification
Every output is decoded from registered state only. A start request taken at a clock edge therefore shows as busy and as the first clearing step just after that same edge. Each later phase output changes one edge after the counter that selects it. The bench drives inputs and samples outputs on the falling edge. It checks whole-frame totals (busy length, pulse counts, blanking and sync cycles) against closed-form figures, which do not depend on where a given edge falls. It checks the per-pixel ordering relative to the sampled history of the previous cycle, counting the cycles since each serial clock fell so that the sample delay is compared exactly.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_INTEG, ST_READ} frame_st_e;
  typedef enum logic {SEG_HBLK, SEG_SER} line_seg_e;
endpackage

// File: rtl/ccd_pixel_strobes.sv
module ccd_pixel_strobes #(
  parameter int PIX_CYC = 4,
  localparam int PH_W = $clog2(PIX_CYC),
  localparam int HALF = PIX_CYC / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            drive_i,
  input  logic            first_pix_i,
  input  logic [PH_W-2:0] dly_i,
  output logic            pix_last_o,
  output logic            ser_a_o,
  output logic            ser_b_o,
  output logic            rg_a_o,
  output logic            rg_b_o,
  output logic            clamp_a_o,
  output logic            clamp_b_o,
  output logic            samp_a_o,
  output logic            samp_b_o
);
  logic [PH_W-1:0] ph_q;
  logic            act;
  logic [PH_W-1:0] dly_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (!run_i)                      ph_q <= '0;
    else if (ph_q == PH_W'(PIX_CYC - 1))  ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign act        = run_i & drive_i;
  assign dly_ext    = {1'b0, dly_i};
  assign pix_last_o = run_i & (ph_q == PH_W'(PIX_CYC - 1));

  always_comb begin
    ser_a_o   = act & (ph_q < PH_W'(HALF));
    ser_b_o   = act & (ph_q >= PH_W'(HALF));
    rg_a_o    = act & (ph_q == '0);
    rg_b_o    = act & (ph_q == PH_W'(HALF));
    clamp_a_o = act & (ph_q == PH_W'(1));
    clamp_b_o = act & (ph_q == PH_W'(HALF + 1));
    // channel A falls at mid-pixel, channel B at pixel wrap
    samp_a_o  = act & (ph_q == PH_W'(HALF) + dly_ext);
    samp_b_o  = act & ~first_pix_i & (ph_q == dly_ext);
  end
endmodule

// File: rtl/ccd_hblank_gen.sv
module ccd_hblank_gen #(
  parameter int HB_CYC = 64,
  parameter int IAG_W  = 8,
  parameter int TRG_W  = 8,
  parameter int SYNC_W = 8,
  parameter int AB_W   = 6,
  localparam int HB_W  = $clog2(HB_CYC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            read_i,
  input  logic            integ_i,
  input  logic            first_line_i,
  input  logic [AB_W-1:0] ab_cnt_i,
  output logic            last_o,
  output logic            shift_o,
  output logic            xfer_o,
  output logic            ab_o,
  output logic            sync_o
);
  logic [HB_W-1:0] hc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hc_q <= '0;
    else if (!run_i) hc_q <= '0;
    else             hc_q <= hc_q + 1'b1;
  end

  assign last_o = run_i & (hc_q == HB_W'(HB_CYC - 1));

  always_comb begin
    shift_o = run_i & read_i & (32'(hc_q) < IAG_W);
    xfer_o  = run_i & read_i & (32'(hc_q) >= IAG_W) & (32'(hc_q) < IAG_W + TRG_W);
    ab_o    = run_i & integ_i & ~hc_q[0] & ((32'(hc_q) >> 1) < 32'(ab_cnt_i));
    sync_o  = run_i & (32'(hc_q) < (first_line_i ? 2 * SYNC_W : SYNC_W));
  end
endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import ccd_seq_pkg::*;
#(
  parameter int LINES    = 1024,
  parameter int DATA_EL  = 512,
  parameter int DUMMY_EL = 12,
  parameter int DARK_PIX = 24,
  parameter int PIX_CYC  = 4,
  parameter int HB_CYC   = 64,
  parameter int IAG_W    = 8,
  parameter int TRG_W    = 8,
  parameter int SYNC_W   = 8,
  parameter int CLR_CYC  = 50,
  parameter int SER_W    = 11,
  parameter int INT_W    = 16,
  parameter int AB_W     = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [SER_W-1:0]           ser_cnt_i,
  input  logic [INT_W-1:0]           int_lines_i,
  input  logic [AB_W-1:0]            ab_cnt_i,
  input  logic [$clog2(PIX_CYC)-2:0] sh_dly_i,
  output logic                       busy_o,
  output logic                       img_shift_o,
  output logic                       ab_gate_o,
  output logic                       xfer_o,
  output logic                       ser_a_o,
  output logic                       ser_b_o,
  output logic                       rg_a_o,
  output logic                       rg_b_o,
  output logic                       clamp_a_o,
  output logic                       clamp_b_o,
  output logic                       samp_a_o,
  output logic                       samp_b_o,
  output logic                       dclamp_a_o,
  output logic                       dclamp_b_o,
  output logic                       sync_o,
  output logic                       blank_o
);
  localparam int MIN_SER = DATA_EL + DUMMY_EL;
  localparam int CLR_W   = $clog2(CLR_CYC);
  localparam int DLY_W   = $clog2(PIX_CYC) - 1;

  frame_st_e        st_q;
  line_seg_e        seg_q;
  logic [CLR_W-1:0] ccnt_q;
  logic [INT_W-1:0] line_q;
  logic [SER_W-1:0] pc_q;
  logic             first_q;
  logic [SER_W-1:0] ser_q;
  logic [INT_W-1:0] int_q;
  logic [AB_W-1:0]  ab_q;
  logic [DLY_W-1:0] dly_q;

  logic in_line, hb_run, px_run, hb_last, pix_last;
  logic hb_shift, px_rg_a, px_rg_b, clr_on, dark_win;

  assign in_line = (st_q == ST_INTEG) || (st_q == ST_READ);
  assign hb_run  = in_line && (seg_q == SEG_HBLK);
  assign px_run  = in_line && (seg_q == SEG_SER);
  assign clr_on  = (st_q == ST_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      seg_q   <= SEG_HBLK;
      ccnt_q  <= '0;
      line_q  <= '0;
      pc_q    <= '0;
      first_q <= 1'b0;
      ser_q   <= SER_W'(MIN_SER);
      int_q   <= '0;
      ab_q    <= '0;
      dly_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_CLEAR;
          ccnt_q <= '0;
          line_q <= '0;
          ser_q  <= (32'(ser_cnt_i) < MIN_SER) ? SER_W'(MIN_SER) : ser_cnt_i;
          int_q  <= int_lines_i;
          ab_q   <= ab_cnt_i;
          dly_q  <= sh_dly_i;
        end
        ST_CLEAR: begin
          if (ccnt_q == CLR_W'(CLR_CYC - 1)) begin
            ccnt_q <= '0;
            if (line_q == INT_W'(LINES - 1)) begin
              line_q  <= '0;
              first_q <= 1'b1;
              seg_q   <= SEG_HBLK;
              st_q    <= (int_q == '0) ? ST_READ : ST_INTEG;
            end else begin
              line_q <= line_q + 1'b1;
            end
          end else begin
            ccnt_q <= ccnt_q + 1'b1;
          end
        end
        default: begin
          if (seg_q == SEG_HBLK) begin
            if (hb_last) begin
              seg_q   <= SEG_SER;
              pc_q    <= '0;
              first_q <= 1'b0;
            end
          end else if (pix_last) begin
            if (pc_q == ser_q - 1'b1) begin
              seg_q <= SEG_HBLK;
              pc_q  <= '0;
              if (st_q == ST_INTEG && line_q == int_q - 1'b1) begin
                st_q   <= ST_READ;
                line_q <= '0;
              end else if (st_q == ST_READ && line_q == INT_W'(LINES - 1)) begin
                st_q   <= ST_IDLE;
                line_q <= '0;
              end else begin
                line_q <= line_q + 1'b1;
              end
            end else begin
              pc_q <= pc_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  ccd_hblank_gen #(
    .HB_CYC(HB_CYC), .IAG_W(IAG_W), .TRG_W(TRG_W), .SYNC_W(SYNC_W), .AB_W(AB_W)
  ) u_hblank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (hb_run),
    .read_i       (st_q == ST_READ),
    .integ_i      (st_q == ST_INTEG),
    .first_line_i (first_q),
    .ab_cnt_i     (ab_q),
    .last_o       (hb_last),
    .shift_o      (hb_shift),
    .xfer_o       (xfer_o),
    .ab_o         (ab_gate_o),
    .sync_o       (sync_o)
  );

  ccd_pixel_strobes #(.PIX_CYC(PIX_CYC)) u_pix (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (px_run),
    .drive_i     (st_q == ST_READ),
    .first_pix_i (pc_q == '0),
    .dly_i       (dly_q),
    .pix_last_o  (pix_last),
    .ser_a_o     (ser_a_o),
    .ser_b_o     (ser_b_o),
    .rg_a_o      (px_rg_a),
    .rg_b_o      (px_rg_b),
    .clamp_a_o   (clamp_a_o),
    .clamp_b_o   (clamp_b_o),
    .samp_a_o    (samp_a_o),
    .samp_b_o    (samp_b_o)
  );

  assign dark_win = px_run && (st_q == ST_READ) &&
                    (32'(pc_q) >= DUMMY_EL) && (32'(pc_q) < DUMMY_EL + DARK_PIX);

  assign busy_o      = (st_q != ST_IDLE);
  assign img_shift_o = hb_shift | (clr_on && (32'(ccnt_q) < CLR_CYC / 2));
  assign rg_a_o      = clr_on | px_rg_a;
  assign rg_b_o      = clr_on | px_rg_b;
  assign dclamp_a_o  = dark_win;
  assign dclamp_b_o  = dark_win;
  assign blank_o     = clr_on | hb_run;
endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic img_shift_o,
  input logic ab_gate_o,
  input logic xfer_o,
  input logic ser_a_o,
  input logic ser_b_o,
  input logic rg_a_o,
  input logic rg_b_o,
  input logic clamp_a_o,
  input logic samp_a_o,
  input logic sync_o,
  input logic blank_o
);
  // R1
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  // R2
  clear_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rg_a_o && rg_b_o) |-> (blank_o && !ser_a_o && !ser_b_o && !xfer_o));
  // R4
  xfer_after_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_o) |-> ($past(img_shift_o) && !img_shift_o));
  // R6
  antiphase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ser_a_o) |-> $rose(ser_b_o));
  // R8
  clamp_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_a_o |-> ($past(rg_a_o) && ser_a_o));
  // R9
  sample_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_a_o |-> (!ser_a_o && ser_b_o));
  // R11
  serial_unblank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_a_o || ser_b_o) |-> !blank_o);
  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(img_shift_o || ab_gate_o || xfer_o || ser_a_o || ser_b_o ||
                  rg_a_o || rg_b_o || sync_o || blank_o));
endmodule

bind ccd_frame_seq ccd_frame_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .img_shift_o (img_shift_o),
  .ab_gate_o   (ab_gate_o),
  .xfer_o      (xfer_o),
  .ser_a_o     (ser_a_o),
  .ser_b_o     (ser_b_o),
  .rg_a_o      (rg_a_o),
  .rg_b_o      (rg_b_o),
  .clamp_a_o   (clamp_a_o),
  .samp_a_o    (samp_a_o),
  .sync_o      (sync_o),
  .blank_o     (blank_o)
);

// File: tb/sim_ccd_frame_seq.sv
module sim_ccd_frame_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] ser_cnt = '0;
  logic [7:0] int_lines = '0;
  logic [5:0] ab_cnt = '0;
  logic [0:0] sh_dly = '0;
  logic busy, shift, abg, xfer, sa, sb, ra, rb, ca, cb, pa, pb, da, db, sync, blank;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ccd_frame_seq #(
    .LINES(4), .DATA_EL(8), .DUMMY_EL(2), .DARK_PIX(3), .PIX_CYC(4),
    .HB_CYC(16), .IAG_W(2), .TRG_W(2), .SYNC_W(3), .CLR_CYC(4),
    .SER_W(8), .INT_W(8), .AB_W(6)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ser_cnt_i(ser_cnt),
    .int_lines_i(int_lines), .ab_cnt_i(ab_cnt), .sh_dly_i(sh_dly),
    .busy_o(busy), .img_shift_o(shift), .ab_gate_o(abg), .xfer_o(xfer),
    .ser_a_o(sa), .ser_b_o(sb), .rg_a_o(ra), .rg_b_o(rb),
    .clamp_a_o(ca), .clamp_b_o(cb), .samp_a_o(pa), .samp_b_o(pb),
    .dclamp_a_o(da), .dclamp_b_o(db), .sync_o(sync), .blank_o(blank)
  );

  // fields: ser, int, ab, dly, busy, shift, xfer, ser_a rises, ab rises,
  //         rg_a rises, dark cycles, sync cycles, blank cycles
  localparam int NV = 3;
  localparam int VEC [NV][13] = '{
    '{12, 2,  3, 0, 400, 8, 4, 48, 6, 49, 48, 21, 112},
    '{ 5, 0,  2, 1, 240, 8, 4, 40, 0, 41, 48, 15,  80},
    '{10, 1, 20, 1, 296, 8, 4, 40, 8, 41, 48, 18,  96}
  };

  int n_busy, n_shift, n_xfer, n_sa, n_ab, n_ra, n_dark, n_sync, n_blank;
  int v_anti, v_rst, v_clamp, v_samp, v_dark2, first_sync, sync_run;
  int since_a, since_b;
  logic p_shift, p_xfer, p_sa, p_sb, p_ab, p_ra, p_rb, p_sync, seen_sync;

  task automatic clr_mon();
    n_busy = 0; n_shift = 0; n_xfer = 0; n_sa = 0; n_ab = 0; n_ra = 0;
    n_dark = 0; n_sync = 0; n_blank = 0; v_anti = 0; v_rst = 0; v_clamp = 0;
    v_samp = 0; v_dark2 = 0; first_sync = 0; sync_run = 0; seen_sync = 1'b0;
    since_a = 99; since_b = 99;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) n_busy++;
      if (shift && !p_shift) n_shift++;
      if (xfer && !p_xfer) n_xfer++;
      if (sa && !p_sa) n_sa++;
      if (abg && !p_ab) n_ab++;
      if (ra && !p_ra) n_ra++;
      if (da) n_dark++;
      if (da != db) v_dark2++;
      if (sync) n_sync++;
      if (blank) n_blank++;
      if ((sa || sb) && (sa == sb)) v_anti++;
      if (ra && !rb && !(sa && !p_sa)) v_rst++;
      if (rb && !ra && !(sb && !p_sb)) v_rst++;
      if (ca && !(p_ra && sa)) v_clamp++;
      if (cb && !(p_rb && sb)) v_clamp++;
      since_a = (p_sa && !sa) ? 0 : since_a + 1;
      since_b = (p_sb && !sb) ? 0 : since_b + 1;
      if (pa && since_a != int'(sh_dly)) v_samp++;
      if (pb && since_b != int'(sh_dly)) v_samp++;
      if (sync) sync_run++;
      if (!sync && p_sync && !seen_sync) begin first_sync = sync_run; seen_sync = 1'b1; end
    end
    p_shift = shift; p_xfer = xfer; p_sa = sa; p_sb = sb; p_ab = abg;
    p_ra = ra; p_rb = rb; p_sync = sync;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic int idle_outs();
    return int'({shift, abg, xfer, sa, sb, ra, rb, ca, cb, pa, pb, da, db, sync, blank, busy});
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    chk("R13 reset outputs", idle_outs(), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 idle after reset", idle_outs(), 0);

    for (int i = 0; i < NV; i++) begin
      ser_cnt = 8'(VEC[i][0]); int_lines = 8'(VEC[i][1]);
      ab_cnt = 6'(VEC[i][2]); sh_dly = 1'(VEC[i][3]);
      clr_mon();
      pulse_start();
      chk("R1 busy after start", int'(busy), 1);
      wait_idle();
      chk("R1 frame length", n_busy, VEC[i][4]);
      chk("R2 R4 image shifts", n_shift, VEC[i][5]);
      chk("R4 transfer pulses", n_xfer, VEC[i][6]);
      chk("R5 serial pixels", n_sa, VEC[i][7]);
      chk("R3 antiblooming pulses", n_ab, VEC[i][8]);
      chk("R7 reset pulses", n_ra, VEC[i][9]);
      chk("R10 dark clamp cycles", n_dark, VEC[i][10]);
      chk("R10 dark clamp pair", v_dark2, 0);
      chk("R12 sync cycles", n_sync, VEC[i][11]);
      chk("R12 first-line sync width", first_sync, 6);
      chk("R11 blank cycles", n_blank, VEC[i][12]);
      chk("R6 antiphase", v_anti, 0);
      chk("R7 reset placement", v_rst, 0);
      chk("R8 clamp placement", v_clamp, 0);
      chk("R9 sample delay", v_samp, 0);
      chk("R13 idle after frame", idle_outs(), 0);
    end

    // R1: restart and setting changes while busy are ignored
    ser_cnt = 8'd12; int_lines = 8'd2; ab_cnt = 6'd3; sh_dly = 1'b0;
    clr_mon();
    pulse_start();
    repeat (100) @(negedge clk);
    ser_cnt = 8'd30; int_lines = 8'd0;
    pulse_start();
    wait_idle();
    chk("R1 start ignored while busy", n_busy, 400);
    chk("R1 settings held", n_sa, 48);

    // R2: clearing pass holds both resets and pulses the image gate
    clr_mon();
    pulse_start();
    chk("R2 reset gates high in clear", int'({ra, rb, blank}), 7);
    wait_idle();

    // R5: count at the minimum exactly
    ser_cnt = 8'd10; int_lines = 8'd0;
    clr_mon();
    pulse_start();
    wait_idle();
    chk("R5 minimum serial count", n_sa, 40);
    chk("R3 no integration skip", n_busy, 240);

    finish_run();
  end
endmodule